// File: doc/BRIEF.md
# Floating-Point Status and Control Register Unit

This block holds the 32-bit floating-point status and control word of a processor core, and the 32-bit condition register that some of its instructions write. When `op_valid` is high for one cycle, the block decodes the instruction word and performs one of six operations:

- set one status bit;
- clear one status bit;
- write one status nibble from an immediate;
- write any set of nibbles from the low word of a 64-bit operand, chosen by a mask;
- copy a status nibble into a condition-register field, which also clears that nibble's sticky exception flags;
- capture the status word as a 64-bit value.

Exception flags from an arithmetic unit are merged into the status word on every cycle where `arith_valid` is high. Instructions with reserved fields set are reported on the combinational `op_illegal` output and change nothing.

Bit numbering in the requirements uses the usual LSB-zero form. Nibble i is bits [31-4i:28-4i], so nibble 0 is the most significant. Status bit names by position:

| Bit | Flag |
|-----|------|
| 31 | summary-exception (FX) |
| 28 | overflow |
| 27 | underflow |
| 26 | zero-divide |
| 25 | inexact |
| 24 | signalling-NaN invalid |
| 23:20 | the four arithmetic-invalid flags |
| 19 | compare-invalid |
| 8 | convert-invalid |

Top module: `fpsu_top`

## Requirements
- R1: After reset, `fpscr`, `cr` and `rd_data` are all zero. Every update takes effect at the clock edge that samples `op_valid` high, and is visible from then on.
- R2: The operation is selected by `instr[3:1]`: 1 is bit-set, 2 is bit-clear, 3 is immediate nibble write, 4 is masked write, 5 is move-to-condition-field, 6 is read. For codes 1 and 2, n = `instr[25:21]`, and status bit (31-n) is set or cleared.
- R3: The immediate nibble write (code 3) replaces only nibble `instr[25:23]` with `instr[15:12]`.
- R4: The masked write (code 4) takes its mask from `instr[24:17]`. Mask bit (7-i) copies nibble i from `src_op[31:0]`, and nibbles with a zero mask bit keep their value.
- R5: The move-to-condition-field operation (code 5) copies status nibble s = `instr[20:18]` into condition field d = `instr[25:23]` (`cr` bits [31-4d:28-4d]). It then clears sticky flags by s:
  - s=0 clears bits 31 and 28;
  - s=1 clears bits 27:24;
  - s=2 clears bits 23:20;
  - s=3 clears bit 19;
  - s=5 clears bit 8;
  - s=4, 6 and 7 clear nothing.
- R6: A read (code 6) loads `rd_data` with upper word 0xFFF80000 and lower word the status value held before that edge. `rd_data` keeps that value until the next read.
- R7: When `arith_valid` is high, `arith_flags[3:0]` (overflow, underflow, zero-divide, inexact) are ORed into bits 28, 27, 26 and 25. This merge is applied after any instruction in the same cycle. If the merge changes the word, bit 31 is also set.
- R8: When `instr[0]` is set on a legal operation, `cr` bits 27:25 are cleared and bit 24 is kept. This clearing is applied after any field copy.
- R9: `op_illegal` is high, in the same cycle, only while `op_valid` is high and the instruction is one of the following:
  - codes 0 or 7;
  - codes 1, 2 or 6 with any of `instr[20:11]` set;
  - code 3 with any of `instr[26]`, `instr[22:16]` or `instr[11]` set;
  - code 4 with `instr[25]` or `instr[16]` set;
  - code 5 with any of `instr[22:21]`, `instr[17:16]` or `instr[15:11]` set.
  An illegal instruction changes neither register nor `rd_data`.
- R10: While `op_valid` is low, `instr` and `src_op` change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Single-cycle instruction strobe |
| instr | input | 32 | Instruction word |
| src_op | input | 64 | Source operand for the masked write |
| arith_valid | input | 1 | Arithmetic flag report strobe |
| arith_flags | input | 4 | Overflow, underflow, zero-divide, inexact |
| op_illegal | output | 1 | Reserved-field violation (combinational) |
| fpscr | output | 32 | Status and control word |
| cr | output | 32 | Condition register |
| rd_data | output | 64 | Last read value |

## Verification
`op_illegal` is combinational, so it is sampled one time unit after the inputs are driven, in the strobe cycle itself. `fpscr`, `cr` and `rd_data` each pass through exactly one register, so their expected values belong to the edge that samples the strobe. The driver pushes the expected triple just after that edge, and the monitor compares it at the following falling edge, before any later strobe can act.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;
    localparam int NIB_W    = 4;
    localparam int NFIELD   = 8;
    localparam int REG_W    = NIB_W * NFIELD;
    localparam int FLD_W    = $clog2(NFIELD);
    localparam int IDX_W    = $clog2(REG_W);
    localparam logic [REG_W-1:0] READ_PAD = 32'hFFF8_0000;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_BSET = 3'd1,
        OP_BCLR = 3'd2,
        OP_NIMM = 3'd3,
        OP_NMSK = 3'd4,
        OP_MVCR = 3'd5,
        OP_READ = 3'd6,
        OP_RSV  = 3'd7
    } fpsu_op_e;

    // sticky flags dropped when status nibble f is copied out
    function automatic logic [REG_W-1:0] sticky_clear(input logic [FLD_W-1:0] f);
        logic [REG_W-1:0] m;
        m = '0;
        unique case (f)
            3'd0: begin m[31] = 1'b1; m[28] = 1'b1; end
            3'd1: m[27:24] = 4'hF;
            3'd2: m[23:20] = 4'hF;
            3'd3: m[19] = 1'b1;
            3'd5: m[8] = 1'b1;
            default: m = '0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/fpsu_decode.sv
module fpsu_decode
    import fpsu_pkg::*;
(
    input  logic                 op_valid,
    input  logic [31:0]          instr,
    output fpsu_op_e             op_eff,
    output logic                 illegal,
    output logic                 rec_en,
    output logic [IDX_W-1:0]     bit_idx,
    output logic [FLD_W-1:0]     fld_dst,
    output logic [FLD_W-1:0]     fld_src,
    output logic [NIB_W-1:0]     imm_val,
    output logic [NFIELD-1:0]    fmask
);
    fpsu_op_e raw_op;
    logic     rsv_hit;

    assign raw_op  = fpsu_op_e'(instr[3:1]);
    assign bit_idx = instr[25:21];
    assign fld_dst = instr[25:23];
    assign fld_src = instr[20:18];
    assign imm_val = instr[15:12];
    assign fmask   = instr[24:17];

    always_comb begin
        unique case (raw_op)
            OP_BSET, OP_BCLR, OP_READ: rsv_hit = |instr[20:11];
            OP_NIMM: rsv_hit = instr[26] | (|instr[22:16]) | instr[11];
            OP_NMSK: rsv_hit = instr[25] | instr[16];
            OP_MVCR: rsv_hit = (|instr[22:21]) | (|instr[17:16]) | (|instr[15:11]);
            default: rsv_hit = 1'b1;
        endcase
    end

    assign illegal = op_valid & rsv_hit;
    assign op_eff  = (op_valid && !rsv_hit) ? raw_op : OP_NONE;
    assign rec_en  = op_valid & ~rsv_hit & instr[0];
endmodule

// File: rtl/fpsu_status.sv
module fpsu_status
    import fpsu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  fpsu_op_e             op_eff,
    input  logic [IDX_W-1:0]     bit_idx,
    input  logic [FLD_W-1:0]     fld_dst,
    input  logic [FLD_W-1:0]     fld_src,
    input  logic [NIB_W-1:0]     imm_val,
    input  logic [NFIELD-1:0]    fmask,
    input  logic [REG_W-1:0]     src_lo,
    input  logic                 arith_valid,
    input  logic [3:0]           arith_flags,
    output logic [REG_W-1:0]     status_q
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(REG_W - 1);
    localparam int FLAG_LSB = REG_W - 7;

    logic [REG_W-1:0] we_vec, wd_vec, bit_sel, instr_nx, merged;

    for (genvar i = 0; i < NFIELD; i++) begin : g_nib
        localparam int LSB = (NFIELD - 1 - i) * NIB_W;
        logic sel;
        assign sel = ((op_eff == OP_NIMM) && (fld_dst == FLD_W'(i))) ||
                     ((op_eff == OP_NMSK) && fmask[NFIELD-1-i]);
        assign we_vec[LSB +: NIB_W] = {NIB_W{sel}};
        assign wd_vec[LSB +: NIB_W] = (op_eff == OP_NIMM) ? imm_val : src_lo[LSB +: NIB_W];
    end

    assign bit_sel = REG_W'(1) << (TOP_IDX - bit_idx);

    always_comb begin
        instr_nx = status_q;
        unique case (op_eff)
            OP_BSET:          instr_nx = status_q | bit_sel;
            OP_BCLR:          instr_nx = status_q & ~bit_sel;
            OP_NIMM, OP_NMSK: instr_nx = (status_q & ~we_vec) | (wd_vec & we_vec);
            OP_MVCR:          instr_nx = status_q & ~sticky_clear(fld_src);
            default:          instr_nx = status_q;
        endcase
    end

    always_comb begin
        merged = instr_nx;
        if (arith_valid) begin
            merged = instr_nx | (REG_W'(arith_flags) << FLAG_LSB);
            if (merged != instr_nx) merged[REG_W-1] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= merged;
    end
endmodule

// File: rtl/fpsu_cond.sv
module fpsu_cond
    import fpsu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  fpsu_op_e             op_eff,
    input  logic                 rec_en,
    input  logic [FLD_W-1:0]     fld_dst,
    input  logic [FLD_W-1:0]     fld_src,
    input  logic [REG_W-1:0]     status_q,
    output logic [REG_W-1:0]     cr_q
);
    localparam int REC_HI = REG_W - NIB_W - 1;

    logic [REG_W-1:0] cr_nx;

    always_comb begin
        cr_nx = cr_q;
        if (op_eff == OP_MVCR)
            cr_nx[(NFIELD - 1 - int'(fld_dst)) * NIB_W +: NIB_W] =
                status_q[(NFIELD - 1 - int'(fld_src)) * NIB_W +: NIB_W];
        if (rec_en)
            cr_nx[REC_HI -: NIB_W-1] = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cr_q <= '0;
        else        cr_q <= cr_nx;
    end
endmodule

// File: rtl/fpsu_top.sv
module fpsu_top
    import fpsu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    input  logic [31:0] instr,
    input  logic [63:0] src_op,
    input  logic        arith_valid,
    input  logic [3:0]  arith_flags,
    output logic        op_illegal,
    output logic [31:0] fpscr,
    output logic [31:0] cr,
    output logic [63:0] rd_data
);
    fpsu_op_e            op_eff;
    logic                rec_en;
    logic [IDX_W-1:0]    bit_idx;
    logic [FLD_W-1:0]    fld_dst, fld_src;
    logic [NIB_W-1:0]    imm_val;
    logic [NFIELD-1:0]   fmask;
    logic [REG_W-1:0]    status_q, cr_q;
    logic [2*REG_W-1:0]  rd_q;

    fpsu_decode u_dec (
        .op_valid (op_valid),
        .instr    (instr),
        .op_eff   (op_eff),
        .illegal  (op_illegal),
        .rec_en   (rec_en),
        .bit_idx  (bit_idx),
        .fld_dst  (fld_dst),
        .fld_src  (fld_src),
        .imm_val  (imm_val),
        .fmask    (fmask)
    );

    fpsu_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_eff      (op_eff),
        .bit_idx     (bit_idx),
        .fld_dst     (fld_dst),
        .fld_src     (fld_src),
        .imm_val     (imm_val),
        .fmask       (fmask),
        .src_lo      (src_op[REG_W-1:0]),
        .arith_valid (arith_valid),
        .arith_flags (arith_flags),
        .status_q    (status_q)
    );

    fpsu_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_eff   (op_eff),
        .rec_en   (rec_en),
        .fld_dst  (fld_dst),
        .fld_src  (fld_src),
        .status_q (status_q),
        .cr_q     (cr_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                rd_q <= '0;
        else if (op_eff == OP_READ) rd_q <= {READ_PAD, status_q};
    end

    assign fpscr   = status_q;
    assign cr      = cr_q;
    assign rd_data = rd_q;
endmodule

// File: rtl/fpsu_checker.sv
module fpsu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [31:0] instr,
    input logic        arith_valid,
    input logic [3:0]  arith_flags,
    input logic        op_illegal,
    input logic [31:0] fpscr,
    input logic [31:0] cr,
    input logic [63:0] rd_data
);
    logic legal_op;
    assign legal_op = op_valid && !op_illegal;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !op_illegal);                                          // R9
    AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_illegal && !arith_valid) |=> (fpscr == $past(fpscr)) && (cr == $past(cr))); // R9
    AST_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_op && instr[3:1] == 3'd1) |=> fpscr[5'd31 - $past(instr[25:21])]); // R2
    AST_BIT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_op && instr[3:1] == 3'd2 && !arith_valid) |=> !fpscr[5'd31 - $past(instr[25:21])]); // R2
    AST_MOVE_CLR0: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_op && instr[3:1] == 3'd5 && instr[20:18] == 3'd0 && !arith_valid)
        |=> !fpscr[31] && !fpscr[28]);                                      // R5
    AST_READ_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_op && instr[3:1] == 3'd6) |=> rd_data == {32'hFFF8_0000, $past(fpscr)}); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (arith_valid && arith_flags[3]) |=> fpscr[28]);                     // R7
    AST_RECORD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_op && instr[0]) |=> cr[27:25] == 3'b000);                   // R8
endmodule

bind fpsu_top fpsu_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .instr       (instr),
    .arith_valid (arith_valid),
    .arith_flags (arith_flags),
    .op_illegal  (op_illegal),
    .fpscr       (fpscr),
    .cr          (cr),
    .rd_data     (rd_data)
);

// File: tb/fpsu_top_tb.sv
`timescale 1ns/1ps
module fpsu_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] src_op = '0;
    logic        arith_valid = 1'b0;
    logic [3:0]  arith_flags = '0;
    logic        op_illegal;
    logic [31:0] fpscr, cr;
    logic [63:0] rd_data;

    always #2 clk = ~clk;

    fpsu_top u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .instr(instr), .src_op(src_op),
        .arith_valid(arith_valid), .arith_flags(arith_flags), .op_illegal(op_illegal),
        .fpscr(fpscr), .cr(cr), .rd_data(rd_data)
    );

    typedef struct {
        logic [31:0] f;
        logic [31:0] c;
        logic [63:0] r;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_vec = 0;
    int          n_bad = 0;
    logic [31:0] m_f = '0, m_c = '0;
    logic [63:0] m_r = '0;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_bit(bit clr, int n, bit rec);
        return (32'(n) << 21) | (clr ? 32'd4 : 32'd2) | 32'(rec);
    endfunction
    function automatic logic [31:0] mk_imm(int f, int v, bit rec);
        return (32'(f) << 23) | (32'(v) << 12) | 32'd6 | 32'(rec);
    endfunction
    function automatic logic [31:0] mk_msk(int m, bit rec);
        return (32'(m) << 17) | 32'd8 | 32'(rec);
    endfunction
    function automatic logic [31:0] mk_mv(int d, int s, bit rec);
        return (32'(d) << 23) | (32'(s) << 18) | 32'd10 | 32'(rec);
    endfunction
    function automatic logic [31:0] mk_rd(bit rec);
        return 32'd12 | 32'(rec);
    endfunction

    function automatic bit ref_illegal(logic [31:0] i);
        case (i[3:1])
            3'd1, 3'd2, 3'd6: return |i[20:11];
            3'd3: return i[26] | (|i[22:16]) | i[11];
            3'd4: return i[25] | i[16];
            3'd5: return (|i[22:21]) | (|i[17:16]) | (|i[15:11]);
            default: return 1'b1;
        endcase
    endfunction

    task automatic issue(bit v, logic [31:0] ins, logic [63:0] src, bit av, logic [3:0] fl, string tag);
        logic [31:0] nf, nc, t;
        logic [63:0] nr;
        bit          ill;
        int          d, s;
        @(negedge clk);
        op_valid = v; instr = ins; src_op = src; arith_valid = av; arith_flags = fl;
        #1;
        ill = v && ref_illegal(ins);
        chk({tag, " R9 illegal"}, 64'(op_illegal), 64'(ill));
        nf = m_f; nc = m_c; nr = m_r;
        if (v && !ill) begin
            case (ins[3:1])
                3'd1: nf[31 - int'(ins[25:21])] = 1'b1;
                3'd2: nf[31 - int'(ins[25:21])] = 1'b0;
                3'd3: nf[31 - 4*int'(ins[25:23]) -: 4] = ins[15:12];
                3'd4: for (int k = 0; k < 8; k++)
                          if (ins[24-k]) nf[31-4*k -: 4] = src[31-4*k -: 4];
                3'd5: begin
                    d = int'(ins[25:23]); s = int'(ins[20:18]);
                    nc[31-4*d -: 4] = m_f[31-4*s -: 4];
                    case (s)
                        0: begin nf[31] = 1'b0; nf[28] = 1'b0; end
                        1: nf[27:24] = 4'h0;
                        2: nf[23:20] = 4'h0;
                        3: nf[19] = 1'b0;
                        5: nf[8] = 1'b0;
                        default: ;
                    endcase
                end
                3'd6: nr = {32'hFFF8_0000, m_f};
                default: ;
            endcase
            if (ins[0]) nc[27:25] = 3'b000;
        end
        if (av) begin
            t = nf | (32'(fl) << 25);
            if (t != nf) t[31] = 1'b1;
            nf = t;
        end
        @(posedge clk);
        #1;
        sb.push_back('{nf, nc, nr, tag});
        m_f = nf; m_c = nc; m_r = nr;
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk({e.tag, " status"}, 64'(fpscr), 64'(e.f));
            chk({e.tag, " cond"},   64'(cr),    64'(e.c));
            chk({e.tag, " read"},   rd_data,    e.r);
        end
    end

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset status", 64'(fpscr), 64'h0);
        chk("R1 reset cond", 64'(cr), 64'h0);
        chk("R1 reset read", rd_data, 64'h0);

        issue(1, mk_bit(0, 0, 0), '0, 0, 0, "R2 set n0");
        issue(1, mk_bit(0, 31, 0), '0, 0, 0, "R2 set n31");
        issue(1, mk_bit(1, 0, 0), '0, 0, 0, "R2 clr n0");
        issue(1, mk_imm(2, 10, 0), '0, 0, 0, "R3 imm f2");
        issue(1, mk_imm(7, 5, 0), '0, 0, 0, "R3 imm f7");
        issue(1, mk_msk(8'hA5, 0), 64'h1234_5678_9ABC_DEF0, 0, 0, "R4 mask a5");
        issue(1, mk_msk(8'h00, 0), 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R4 mask none");
        issue(1, mk_msk(8'h01, 0), 64'h0000_0000_0000_000C, 0, 0, "R4 mask last");
        issue(1, mk_rd(0), '0, 0, 0, "R6 read");
        issue(1, mk_msk(8'hFF, 0), 64'h0, 0, 0, "R4 zero all");
        issue(1, '0, '0, 1, 4'b1000, "R7 ovf");
        issue(1, mk_bit(1, 0, 0), '0, 0, 0, "R7 clr fx");
        issue(1, '0, '0, 1, 4'b1000, "R7 no change");
        issue(1, mk_bit(0, 0, 0), '0, 1, 4'b0011, "R7 merge after op");
        issue(1, mk_msk(8'hFF, 0), 64'hFFFF_FFFF, 0, 0, "R5 fill");
        issue(1, mk_mv(3, 0, 0), '0, 0, 0, "R5 mv s0");
        issue(1, mk_mv(6, 1, 0), '0, 0, 0, "R5 mv s1");
        issue(1, mk_mv(0, 2, 0), '0, 0, 0, "R5 mv s2");
        issue(1, mk_mv(7, 3, 0), '0, 0, 0, "R5 mv s3");
        issue(1, mk_mv(2, 4, 0), '0, 0, 0, "R5 mv s4");
        issue(1, mk_mv(5, 5, 0), '0, 0, 0, "R5 mv s5");
        issue(1, mk_mv(4, 7, 0), '0, 0, 0, "R5 mv s7");
        issue(1, mk_mv(1, 6, 1), '0, 0, 0, "R8 mv rec f1");
        issue(1, mk_mv(1, 6, 0), '0, 0, 0, "R5 mv f1");
        issue(1, mk_rd(1), '0, 0, 0, "R8 R6 read rec");
        issue(1, mk_mv(0, 0, 0) | 32'h0000_0800, '0, 0, 0, "R9 mv rb");
        issue(1, mk_mv(0, 0, 0) | 32'h0020_0000, '0, 0, 0, "R9 mv dst low");
        issue(1, mk_rd(0) | 32'h0001_0000, '0, 0, 0, "R9 read ra");
        issue(1, mk_imm(8, 15, 1), '0, 0, 0, "R9 imm b26");
        issue(1, mk_msk(8'hFF, 0) | 32'h0001_0000, 64'h0, 0, 0, "R9 mask b16");
        issue(1, mk_bit(0, 3, 0) | 32'h0000_0800, '0, 0, 0, "R9 set rb");
        issue(1, 32'h0000_0001, '0, 0, 0, "R9 code0");
        issue(1, 32'h0000_000E, '0, 0, 0, "R9 code7");
        issue(0, mk_msk(8'hFF, 1), 64'h0, 0, 0, "R10 idle mask");
        issue(0, mk_rd(0), '0, 0, 0, "R10 idle read");
        issue(1, mk_rd(0), '0, 0, 0, "R10 read after idle");
        issue(0, '0, '0, 0, 0, "R1 quiet");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule